// File: doc/BRIEF.md
# Flash Hardware Reset and Ready/Busy Sequencer

This block governs how a flash memory device reacts to its active-low hardware reset pin, and it produces the device's ready/busy output. The pin is sampled on the block clock. A low pulse counts as a real reset only once it has lasted a minimum number of samples. A real reset tells the embedded program/erase engine to abandon its work. It also commands the command state machine back to array-read mode.

While the pin is low, the data outputs are floated and the array access path is blocked. After the pin rises, reads are kept blocked until a recovery hold has passed. They also stay blocked until the internal reset has finished. The internal reset takes longer when an embedded operation was running at the moment the pin first went low. In that case the ready/busy output stays at busy for the whole longer interval. The aborted operation is never resumed, so the host must write a fresh command sequence afterwards.

All durations are parameters counted in clock cycles. The parameters must satisfy T_READY_BUSY > T_RP.

Top module: `flash_rst_seq`

## Requirements
- R1: After the block reset `rst_n` is released, and with the reset pin high, the block is in read mode with no command needed. In that state `access_block` and `dq_tristate` are 0, `eng_abort` and `sm_to_read` are 0, and `ry_by` equals the inverse of `eng_busy`.
- R2: When no reset sequence is active, `ry_by` is combinationally the inverse of `eng_busy`. Here 1 means ready and 0 means busy.
- R3: Consider the first clock edge that samples `rst_pin_n` low and the first edge that samples it high again. In every cycle that follows the first of these edges, up to and including the cycle that ends with the second, both `dq_tristate` and `access_block` are 1.
- R4: A low pulse seen on fewer than T_RP consecutive edges is discarded. No `eng_abort` or `sm_to_read` is issued, `ry_by` keeps following `eng_busy`, and `access_block` returns to 0 in the cycle after the first high sample.
- R5: On the edge that takes the T_RP-th consecutive low sample, the reset qualifies. `sm_to_read` is then 1 for exactly the one following cycle.
- R6: `eng_abort` pulses in the same cycle as `sm_to_read`, but only if `eng_busy` was 1 on the edge that took the first low sample.
- R7: Suppose a qualified reset arrives while the engine is busy. Then `ry_by` is 0 from that first low sample until T_READY_BUSY cycles after it, whatever `eng_busy` does. It returns to 1 in the cycle after the edge that ends that interval.
- R8: Suppose a qualified reset arrives while the engine is idle. Then `ry_by` stays 1 throughout. Access remains blocked until T_READY_IDLE cycles after the first low sample, even if the recovery hold has ended sooner.
- R9: After a qualified reset, `access_block` returns to 0 in the cycle after whichever of these edges comes later:
  - the edge that is T_RH edges after the first high sample;
  - the edge that comes one cycle after the internal reset finishes.
- R10: After recovery, the aborted operation is not resumed. No further strobes appear, and `ry_by` again follows `eng_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset, standing in for power-up |
| rst_pin_n | input | 1 | Device hardware reset pin, active low, sampled on `clk` |
| eng_busy | input | 1 | Embedded program/erase engine busy flag |
| ry_by | output | 1 | Ready/busy output: 1 ready, 0 busy |
| eng_abort | output | 1 | One-cycle strobe telling the engine to abandon its operation |
| dq_tristate | output | 1 | Float the data outputs |
| access_block | output | 1 | Ignore read and write attempts |
| sm_to_read | output | 1 | One-cycle strobe returning the command state machine to array-read mode |

## Verification
The main sequence is driven with four kinds of low pulse:
- A pulse too short to qualify, taken once with the engine busy and once idle. This separates discarding from aborting.
- A minimum-length reset with the engine idle. This shows that the idle internal-reset time, rather than the recovery hold, sets when access reopens.
- A long reset with the engine idle. Here the recovery hold after release decides instead.
- A long reset with the engine busy. This shows the abort strobe and the busy hold on the ready/busy output, and that this hold outlasts the engine's own busy flag.

Each pulse is followed by quiet cycles in which the engine flag is toggled. These confirm that nothing is resumed and that ready/busy again follows the engine.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [1:0] {
    FRS_RUN   = 2'd0,
    FRS_PEND  = 2'd1,
    FRS_HELD  = 2'd2,
    FRS_RECOV = 2'd3
  } frs_state_e;
endpackage

// File: rtl/frs_sat_count.sv
module frs_sat_count #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                  cnt_d = '0;
    else if (en && cnt != '1) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R7: a saturated count holds, so long windows never wrap around
  a_r7_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && cnt == '1) |=> (cnt == '1));
endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
#(
  parameter int T_RP         = 4,
  parameter int T_READY_IDLE = 10,
  parameter int T_READY_BUSY = 20,
  parameter int T_RH         = 3,
  parameter int W            = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_n,
  input  logic         eng_busy,
  input  logic [W-1:0] low_cnt,
  input  logic [W-1:0] rdy_cnt,
  input  logic [W-1:0] rh_cnt,
  output logic         low_clr,
  output logic         low_en,
  output logic         rdy_clr,
  output logic         rdy_en,
  output logic         rh_clr,
  output logic         rh_en,
  output logic         ry_by,
  output logic         eng_abort,
  output logic         dq_tristate,
  output logic         access_block,
  output logic         sm_to_read
);
  localparam logic [W:0] RP_C   = (W+1)'(T_RP);
  localparam logic [W:0] RDYI_C = (W+1)'(T_READY_IDLE);
  localparam logic [W:0] RDYB_C = (W+1)'(T_READY_BUSY);
  localparam logic [W:0] RH_C   = (W+1)'(T_RH);

  frs_state_e state, state_d;
  logic was_busy, was_busy_d;
  logic abort_d, smr_d;
  logic [W:0] low_nx, rh_nx, rdy_lim;
  logic qualify, ready_done, in_reset, busy_at_arrival;

  assign low_nx     = {1'b0, low_cnt} + (W+1)'(1);
  assign rh_nx      = {1'b0, rh_cnt} + (W+1)'(1);
  assign rdy_lim    = was_busy ? RDYB_C : RDYI_C;
  assign ready_done = {1'b0, rdy_cnt} >= rdy_lim;
  assign qualify    = !pin_n && (low_nx >= RP_C) &&
                      (state == FRS_RUN || state == FRS_PEND);
  assign busy_at_arrival = (state == FRS_RUN) ? eng_busy : was_busy;
  assign in_reset   = (state == FRS_HELD) || (state == FRS_RECOV);

  // counter controls
  assign low_clr = pin_n;
  assign low_en  = !pin_n;
  assign rdy_clr = (state == FRS_RUN);
  assign rdy_en  = 1'b1;
  assign rh_clr  = (state != FRS_RECOV);
  assign rh_en   = pin_n;

  always_comb begin
    state_d    = state;
    was_busy_d = was_busy;
    case (state)
      FRS_RUN: if (!pin_n) begin
        was_busy_d = eng_busy;
        state_d    = qualify ? FRS_HELD : FRS_PEND;
      end
      FRS_PEND: begin
        if (pin_n)        state_d = FRS_RUN;
        else if (qualify) state_d = FRS_HELD;
      end
      FRS_HELD: if (pin_n) state_d = FRS_RECOV;
      FRS_RECOV: begin
        if (!pin_n)                           state_d = FRS_HELD;
        else if (rh_nx >= RH_C && ready_done) state_d = FRS_RUN;
      end
      default: state_d = FRS_RUN;
    endcase
    smr_d   = qualify;
    abort_d = qualify && busy_at_arrival;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= FRS_RUN;
      was_busy   <= 1'b0;
      sm_to_read <= 1'b0;
      eng_abort  <= 1'b0;
    end else begin
      state      <= state_d;
      was_busy   <= was_busy_d;
      sm_to_read <= smr_d;
      eng_abort  <= abort_d;
    end
  end

  assign dq_tristate  = (state == FRS_PEND) || (state == FRS_HELD);
  assign access_block = (state != FRS_RUN);
  assign ry_by = !((in_reset && was_busy && !ready_done) ||
                   (!in_reset && eng_busy));

  // R3: floated outputs always come with blocked access
  a_r3_tristate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dq_tristate |-> access_block);
  // R4: a pulse released before qualifying leaves no strobe behind
  a_r4_short_pulse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FRS_PEND && pin_n) |=> (state == FRS_RUN && !sm_to_read && !eng_abort));
  // R5: the return-to-read strobe lasts one cycle
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sm_to_read |=> !sm_to_read);
  // R6: an abort only accompanies a qualified reset
  a_r6_abort_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> sm_to_read);
  // R7: ready may rise inside a reset only once the internal reset is done
  a_r7_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ry_by) && in_reset) |-> ready_done);
  // R9: recovery never ends before the hold after release
  a_r9_hold_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FRS_RECOV && pin_n && rh_nx < RH_C) |=> (state != FRS_RUN));
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
  parameter int T_RP         = 4,
  parameter int T_READY_IDLE = 10,
  parameter int T_READY_BUSY = 20,
  parameter int T_RH         = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin_n,
  input  logic eng_busy,
  output logic ry_by,
  output logic eng_abort,
  output logic dq_tristate,
  output logic access_block,
  output logic sm_to_read
);
  localparam int MAX_A = (T_RP > T_RH) ? T_RP : T_RH;
  localparam int MAX_B = (T_READY_IDLE > T_READY_BUSY) ? T_READY_IDLE : T_READY_BUSY;
  localparam int MAXV  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int W     = $clog2(MAXV + 2);

  logic [W-1:0] low_cnt, rdy_cnt, rh_cnt;
  logic low_clr, low_en, rdy_clr, rdy_en, rh_clr, rh_en;

  frs_sat_count #(.W(W)) u_low (.clk(clk), .rst_n(rst_n), .clr(low_clr), .en(low_en), .cnt(low_cnt));
  frs_sat_count #(.W(W)) u_rdy (.clk(clk), .rst_n(rst_n), .clr(rdy_clr), .en(rdy_en), .cnt(rdy_cnt));
  frs_sat_count #(.W(W)) u_rh  (.clk(clk), .rst_n(rst_n), .clr(rh_clr),  .en(rh_en),  .cnt(rh_cnt));

  frs_ctrl #(
    .T_RP(T_RP), .T_READY_IDLE(T_READY_IDLE), .T_READY_BUSY(T_READY_BUSY),
    .T_RH(T_RH), .W(W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_n(rst_pin_n), .eng_busy(eng_busy),
    .low_cnt(low_cnt), .rdy_cnt(rdy_cnt), .rh_cnt(rh_cnt),
    .low_clr(low_clr), .low_en(low_en), .rdy_clr(rdy_clr), .rdy_en(rdy_en),
    .rh_clr(rh_clr), .rh_en(rh_en),
    .ry_by(ry_by), .eng_abort(eng_abort), .dq_tristate(dq_tristate),
    .access_block(access_block), .sm_to_read(sm_to_read)
  );
endmodule

// File: tb/flash_rst_seq_test.sv
module flash_rst_seq_test;
  localparam int TRP = 4, TRDI = 10, TRDB = 20, TRH = 3;

  logic clk, rst_n, rst_pin_n, eng_busy;
  logic ry_by, eng_abort, dq_tristate, access_block, sm_to_read;

  flash_rst_seq #(.T_RP(TRP), .T_READY_IDLE(TRDI), .T_READY_BUSY(TRDB), .T_RH(TRH)) uut (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .eng_busy(eng_busy),
    .ry_by(ry_by), .eng_abort(eng_abort), .dq_tristate(dq_tristate),
    .access_block(access_block), .sm_to_read(sm_to_read));

  typedef struct {
    logic ry, tz, blk, abt, smr;
    string t_ry, t_pin, t_smr, t_abt;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string name, string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b at %0t", tag, name, act, expv, $time);
    end
  endtask

  // monitor: compare outputs mid-cycle against the queued expectation
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("ry_by",        e.t_ry,  ry_by,        e.ry);
      chk("dq_tristate",  e.t_pin, dq_tristate,  e.tz);
      chk("access_block", e.t_pin, access_block, e.blk);
      chk("sm_to_read",   e.t_smr, sm_to_read,   e.smr);
      chk("eng_abort",    e.t_abt, eng_abort,    e.abt);
    end
  end

  task automatic drive(logic pin, logic busy, exp_t e);
    @(posedge clk); #1;
    rst_pin_n = pin;
    eng_busy  = busy;
    q.push_back(e);
  endtask

  task automatic quiet(logic busy, string tag);
    exp_t e;
    e.ry = !busy; e.tz = 0; e.blk = 0; e.abt = 0; e.smr = 0;
    e.t_ry = tag; e.t_pin = tag; e.t_smr = tag; e.t_abt = tag;
    drive(1'b1, busy, e);
  endtask

  // one reset pulse of len low cycles starting at relative cycle 0
  task automatic pulse(int len, logic busy);
    bit qual;
    int lrdy, mrel, hold_end, last;
    qual     = (len >= TRP);
    lrdy     = busy ? TRDB : TRDI;
    hold_end = len + 1 + TRH;
    mrel     = qual ? ((hold_end > lrdy + 2) ? hold_end : lrdy + 2) : len + 1;
    last     = mrel + 2;
    for (int j = 0; j <= last; j++) begin
      exp_t e;
      logic bin;
      bin = busy && (!qual || j < TRP) && (j <= len + 1);
      e.tz  = (j >= 1 && j <= len);
      e.blk = (j >= 1 && j < mrel);
      e.smr = qual && (j == TRP);
      e.abt = qual && busy && (j == TRP);
      if (!qual) begin
        e.ry = !bin;
        e.t_ry = "R4"; e.t_pin = "R4"; e.t_smr = "R4"; e.t_abt = "R4";
      end else begin
        e.ry = busy ? (j > lrdy) : 1'b1;
        e.t_ry  = busy ? "R7" : "R8";
        e.t_pin = (j <= len) ? "R3" : ((!busy && j < lrdy + 2) ? "R8" : "R9");
        e.t_smr = "R5";
        e.t_abt = "R6";
      end
      if (j >= mrel) begin
        e.t_ry = "R10"; e.t_pin = "R10"; e.t_smr = "R10"; e.t_abt = "R10";
      end
      drive(j < len ? 1'b0 : 1'b1, bin, e);
    end
  endtask

  initial begin
    rst_n = 1'b0; rst_pin_n = 1'b1; eng_busy = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: idle read mode after power-up
    repeat (3) quiet(1'b0, "R1");
    // R2: ready/busy follows the engine
    quiet(1'b1, "R2"); quiet(1'b1, "R2"); quiet(1'b0, "R2"); quiet(1'b1, "R2");
    // short pulse while busy, then while idle
    pulse(2, 1'b1);
    quiet(1'b0, "R2");
    pulse(TRP - 1, 1'b0);
    // minimum reset while idle: idle ready time dominates
    pulse(TRP, 1'b0);
    // long reset while idle: recovery hold dominates
    pulse(15, 1'b0);
    // long reset while busy
    quiet(1'b1, "R2");
    pulse(15, 1'b1);
    // R10: no resume, engine flag followed again
    quiet(1'b1, "R10"); quiet(1'b0, "R10"); quiet(1'b0, "R10");
    @(negedge clk); @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule